// File: doc/BRIEF.md
# Replication Victim Tag Filter

This block keeps a small set-associative record of partial tags for second-level cache blocks that were pushed out by a replica. Its purpose is to tell a replication level controller how often an off-chip miss would have been avoided at a lower replication setting. Each time the cache evicts a block, it offers the block address together with a flag that says whether a replica allocated at the current level caused the eviction. Replica-caused evictions always take an entry. Any other eviction only overwrites an entry that is already valid, so unrelated traffic can refresh the record but can never grow it.

On every off-chip miss the address is probed. If the partial tag matches a valid entry in the selected set, a single-cycle hit pulse goes to the controller one clock later, and the matching entry is consumed. Because only a slice of the address is kept, two addresses that share the index and the stored slice are treated as the same block. This aliasing is accepted. When the controller lowers the replication level, it pulses a flush that empties the whole record in one cycle.

The default geometry is 64 sets of 16 ways with 16-bit partial tags. The set count, associativity, partial-tag width and address width are all parameters.

Top module: `victim_tag_buf`

## Requirements
- R1: The set index is the lowest SET_W bits of the block address. The partial tag is the PTAG_W bits directly above the index. A probe compares only against the indexed set, and address bits above the partial tag are ignored.
- R2: An eviction with the replication flag set always writes its partial tag. It goes into the lowest-numbered invalid way of the set when one exists.
- R3: An eviction with the replication flag clear has no effect on a set that still has an invalid way.
- R4: When the set has no invalid way, an eviction of either kind overwrites the way named by that set's rotating pointer. The pointer starts at way 0 and advances by one, modulo WAYS, after each such overwrite.
- R5: `probe_hit` is high for exactly the one cycle after a probe whose partial tag matches a valid entry in the indexed set. It is low in every other cycle.
- R6: A probe that hits invalidates every matching entry in that set.
- R7: A probe in the same cycle as an eviction sees the contents from before that eviction. If the probe's invalidation and the eviction's write land on the same way, the write wins.
- R8: `flush` invalidates all entries and returns all rotating pointers to way 0 in one cycle. An eviction offered in the flush cycle is dropped. A probe in the flush cycle reports against the contents from before the flush.
- R9: While `rst_n` is low, every entry is invalid, every pointer is 0 and `probe_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | An eviction is offered this cycle |
| ev_addr | input | ADDR_W | Block address of the evicted line |
| ev_by_repl | input | 1 | The eviction was caused by a replica allocated at the current level |
| probe_valid | input | 1 | An off-chip miss probe is offered this cycle |
| probe_addr | input | ADDR_W | Block address of the missing line |
| flush | input | 1 | Invalidate the whole record (level decreased) |
| probe_hit | output | 1 | One-cycle pulse for a probe that matched |

## Verification
A probe and an eviction can arrive in the same cycle, and either one can also coincide with a flush. The bench provokes these collisions on purpose. In one case an eviction and a probe carry the same address. In another, a probe removes the entry that the rotating pointer is about to overwrite. Flushes are also issued alongside probes of stored tags and alongside replica evictions. Each result is judged against a bench model that applies every probe to the contents from before the edge, lets a write win over an invalidation of the same way, and drops evictions during a flush. A long pseudo-random sweep on a four-set, four-way configuration then mixes all three operations, using a narrow tag space so that collisions are common.

// File: rtl/vtb_pkg.sv
package vtb_pkg;

   // Where the victim way of an eviction came from
   typedef enum logic {
      SRC_FREE  = 1'b0,   // lowest invalid way
      SRC_ROTOR = 1'b1    // per-set rotating pointer (set was full)
   } vsrc_e;

endpackage

// File: rtl/vtb_way_pick.sv
module vtb_way_pick
   import vtb_pkg::*;
#(
   parameter int WAYS  = 16,
   parameter int WAY_W = 4
) (
   input  logic [WAYS-1:0]  occ,
   input  logic [WAY_W-1:0] rotor,
   output logic [WAY_W-1:0] way,
   output vsrc_e            src
);

   always_comb begin
      way = rotor;
      src = SRC_ROTOR;
      // descending scan: the last assignment is the lowest free way
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (!occ[i]) begin
            way = WAY_W'(i);
            src = SRC_FREE;
         end
      end
   end

endmodule

// File: rtl/vtb_tag_cmp.sv
module vtb_tag_cmp #(
   parameter int WAYS   = 16,
   parameter int PTAG_W = 16
) (
   input  logic [WAYS-1:0]             occ,
   input  logic [WAYS-1:0][PTAG_W-1:0] tags,
   input  logic [PTAG_W-1:0]           key,
   output logic [WAYS-1:0]             match
);

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign match[w] = occ[w] && (tags[w] == key);
   end

endmodule

// File: rtl/victim_tag_buf.sv
module victim_tag_buf
   import vtb_pkg::*;
#(
   parameter int SET_W  = 6,
   parameter int WAYS   = 16,
   parameter int PTAG_W = 16,
   parameter int ADDR_W = 34
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic              ev_by_repl,
   input  logic              probe_valid,
   input  logic [ADDR_W-1:0] probe_addr,
   input  logic              flush,
   output logic              probe_hit
);

   localparam int SETS  = 1 << SET_W;
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

   if (ADDR_W < SET_W + PTAG_W) begin : g_bad_addr
      $error("victim_tag_buf: ADDR_W too narrow for index plus partial tag");
   end
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("victim_tag_buf: WAYS must be a power of two of at least 2");
   end
   if (SET_W < 1 || PTAG_W < 1) begin : g_bad_dims
      $error("victim_tag_buf: SET_W and PTAG_W must be positive");
   end

   // storage
   logic [WAYS-1:0]             occ_q   [SETS];
   logic [WAYS-1:0]             occ_d   [SETS];
   logic [WAYS-1:0][PTAG_W-1:0] tag_q   [SETS];
   logic [WAY_W-1:0]            rotor_q [SETS];

   // address split
   logic [SET_W-1:0]  ev_set,  pr_set;
   logic [PTAG_W-1:0] ev_tag,  pr_tag;
   assign ev_set = ev_addr[SET_W-1:0];
   assign ev_tag = ev_addr[SET_W +: PTAG_W];
   assign pr_set = probe_addr[SET_W-1:0];
   assign pr_tag = probe_addr[SET_W +: PTAG_W];

   // probe side, pre-edge contents
   logic [WAYS-1:0] pr_match;
   vtb_tag_cmp #(.WAYS(WAYS), .PTAG_W(PTAG_W)) u_cmp (
      .occ   (occ_q[pr_set]),
      .tags  (tag_q[pr_set]),
      .key   (pr_tag),
      .match (pr_match)
   );

   logic [WAYS-1:0] pr_kill;
   assign pr_kill = probe_valid ? pr_match : '0;

   // eviction side
   logic [WAY_W-1:0] ev_way;
   vsrc_e            ev_src;
   vtb_way_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
      .occ   (occ_q[ev_set]),
      .rotor (rotor_q[ev_set]),
      .way   (ev_way),
      .src   (ev_src)
   );

   logic ev_wr;
   assign ev_wr = ev_valid && !flush && (ev_by_repl || ev_src == SRC_ROTOR);

   // per-set valid bits and rotating pointers
   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic hit_here, wr_here;
      assign hit_here = (pr_set == SET_W'(s));
      assign wr_here  = ev_wr && (ev_set == SET_W'(s));

      always_comb begin
         occ_d[s] = occ_q[s];
         if (hit_here) occ_d[s] = occ_d[s] & ~pr_kill;
         if (wr_here)  occ_d[s][ev_way] = 1'b1;   // write wins
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            occ_q[s]   <= '0;
            rotor_q[s] <= '0;
         end else if (flush) begin
            occ_q[s]   <= '0;
            rotor_q[s] <= '0;
         end else begin
            occ_q[s] <= occ_d[s];
            if (wr_here && ev_src == SRC_ROTOR)
               rotor_q[s] <= rotor_q[s] + 1'b1;
         end
      end
   end

   // tag array: no reset, guarded by valid bits
   always_ff @(posedge clk) begin
      if (ev_wr) tag_q[ev_set][ev_way] <= ev_tag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) probe_hit <= 1'b0;
      else        probe_hit <= |pr_kill;
   end

endmodule

// File: rtl/vtb_chk.sv
module vtb_chk #(
   parameter int ADDR_W = 34
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_valid,
   input logic [ADDR_W-1:0] ev_addr,
   input logic              ev_by_repl,
   input logic              probe_valid,
   input logic [ADDR_W-1:0] probe_addr,
   input logic              flush,
   input logic              probe_hit
);

   // R5
   pulse_needs_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !probe_valid |=> !probe_hit);

   // R2
   repl_evict_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_by_repl && !flush) ##1 (probe_valid && probe_addr == $past(ev_addr))
      |=> probe_hit);

   // R6
   hit_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_hit && probe_valid && $past(probe_valid) && !$past(ev_valid)
       && probe_addr == $past(probe_addr)) |=> !probe_hit);

   // R8
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush ##1 probe_valid |=> !probe_hit);

   // R3
   plain_evict_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush ##1 (ev_valid && !ev_by_repl) ##1 (probe_valid && probe_addr == $past(ev_addr))
      |=> !probe_hit);

   // R9
   always @(posedge clk) begin
      if (!rst_n) reset_quiet_chk: assert (!probe_hit);
   end

endmodule

bind victim_tag_buf vtb_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/victim_tag_buf_test.sv
module victim_tag_buf_test;

   localparam int SW = 2, NW = 4, TW = 4, AW = 8, NS = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic          rst_n, ev_valid, ev_by_repl, probe_valid, flush, probe_hit;
   logic [AW-1:0] ev_addr, probe_addr;

   victim_tag_buf #(.SET_W(SW), .WAYS(NW), .PTAG_W(TW), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_addr(ev_addr),
      .ev_by_repl(ev_by_repl), .probe_valid(probe_valid), .probe_addr(probe_addr),
      .flush(flush), .probe_hit(probe_hit)
   );

   int checks = 0, errors = 0;

   // bench model
   bit            mv [NS][NW];
   logic [TW-1:0] mt [NS][NW];
   int            mp [NS];
   bit            exp_hit;

   function automatic logic [AW-1:0] mk(input int hi, input int tag, input int set);
      return AW'((hi << (SW + TW)) | (tag << SW) | set);
   endfunction

   task automatic check(input string req, input bit act, input bit exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: probe_hit=%0b expected %0b", req, act, exp);
      end
   endtask

   task automatic model(input bit av, input logic [AW-1:0] aa, input bit ar,
                        input bit lv, input logic [AW-1:0] la, input bit cl);
      int ls = int'(la[SW-1:0]);
      int as = int'(aa[SW-1:0]);
      int fr = -1;
      bit m [NW];
      exp_hit = 1'b0;
      for (int w = 0; w < NW; w++) begin
         m[w] = lv && mv[ls][w] && (mt[ls][w] == la[SW +: TW]);
         exp_hit |= m[w];
      end
      for (int w = NW - 1; w >= 0; w--) if (!mv[as][w]) fr = w;
      if (cl) begin
         for (int s = 0; s < NS; s++) begin
            mp[s] = 0;
            for (int w = 0; w < NW; w++) mv[s][w] = 1'b0;
         end
      end else begin
         for (int w = 0; w < NW; w++) if (m[w]) mv[ls][w] = 1'b0;
         if (av) begin
            if (fr >= 0) begin
               if (ar) begin mv[as][fr] = 1'b1; mt[as][fr] = aa[SW +: TW]; end
            end else begin
               mv[as][mp[as]] = 1'b1;
               mt[as][mp[as]] = aa[SW +: TW];
               mp[as] = (mp[as] + 1) % NW;
            end
         end
      end
   endtask

   // drive at a falling edge, result sampled at the next falling edge
   task automatic op(input bit av, input logic [AW-1:0] aa, input bit ar,
                     input bit lv, input logic [AW-1:0] la, input bit cl, input string req);
      ev_valid = av; ev_addr = aa; ev_by_repl = ar;
      probe_valid = lv; probe_addr = la; flush = cl;
      model(av, aa, ar, lv, la, cl);
      @(negedge clk);
      check(req, probe_hit, exp_hit);
   endtask

   task automatic ev(input logic [AW-1:0] a, input bit r, input string req);
      op(1'b1, a, r, 1'b0, '0, 1'b0, req);
   endtask

   task automatic pr(input logic [AW-1:0] a, input bit exp, input string req);
      op(1'b0, '0, 1'b0, 1'b1, a, 1'b0, req);
      check(req, probe_hit, exp);   // explicit expectation as well
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      rst_n = 1'b0; ev_valid = 0; ev_by_repl = 0; probe_valid = 0; flush = 0;
      ev_addr = '0; probe_addr = '0;
      for (int s = 0; s < NS; s++) begin
         mp[s] = 0;
         for (int w = 0; w < NW; w++) begin mv[s][w] = 0; mt[s][w] = '0; end
      end
      repeat (3) @(negedge clk);
      check("R9 reset", probe_hit, 1'b0);
      rst_n = 1'b1;
      pr(mk(0, 0, 0), 1'b0, "R9 empty after reset");

      // R3: plain eviction into a set with free ways does nothing
      ev(mk(0, 5, 1), 1'b0, "R3");
      pr(mk(0, 5, 1), 1'b0, "R3 no fill");

      // R2 / R4: fill set 1, then plain eviction overwrites way 0
      for (int t = 1; t <= 4; t++) ev(mk(0, t, 1), 1'b1, "R2 fill");
      ev(mk(0, 9, 1), 1'b0, "R4 plain into full");
      pr(mk(0, 1, 1), 1'b0, "R4 way0 replaced");
      pr(mk(0, 9, 1), 1'b1, "R4 new tag present");
      // R6: consumed entry
      pr(mk(0, 9, 1), 1'b0, "R6 consumed");
      // R3 again: set now has a free way (way 0)
      ev(mk(0, 10, 1), 1'b0, "R3 free way");
      pr(mk(0, 10, 1), 1'b0, "R3 still absent");
      // R2: replica takes free way 0, set full; rotor at way1 (tag2)
      ev(mk(0, 11, 1), 1'b1, "R2 lowest free");
      ev(mk(0, 12, 1), 1'b1, "R4 rotor way1");
      pr(mk(0, 2, 1), 1'b0, "R4 tag2 evicted");
      pr(mk(0, 11, 1), 1'b1, "R2 tag11 kept");

      // R1: upper bits ignored, other set misses
      ev(mk(3, 7, 2), 1'b1, "R1");
      pr(mk(2, 7, 3), 1'b0, "R1 other set");
      pr(mk(0, 7, 2), 1'b1, "R1 alias hit");

      // R7: same-cycle eviction and probe of same address
      op(1'b1, mk(0, 6, 0), 1'b1, 1'b1, mk(0, 6, 0), 1'b0, "R7 pre-state");
      check("R7 pre-state", probe_hit, 1'b0);
      pr(mk(0, 6, 0), 1'b1, "R7 visible next");

      // R7: write wins over invalidation of the same way
      for (int t = 1; t <= 4; t++) ev(mk(0, t, 3), 1'b1, "R7 fill");
      op(1'b1, mk(0, 13, 3), 1'b0, 1'b1, mk(0, 1, 3), 1'b0, "R7 collide");
      check("R7 collide", probe_hit, 1'b1);
      pr(mk(0, 13, 3), 1'b1, "R7 write wins");

      // R8: flush with probe of stored tag, and with replica eviction
      ev(mk(0, 8, 0), 1'b1, "R8 setup");
      op(1'b1, mk(0, 14, 2), 1'b1, 1'b1, mk(0, 8, 0), 1'b1, "R8 pre-flush probe");
      check("R8 pre-flush probe", probe_hit, 1'b1);
      pr(mk(0, 14, 2), 1'b0, "R8 dropped eviction");
      pr(mk(0, 11, 1), 1'b0, "R8 emptied");
      ev(mk(0, 3, 1), 1'b0, "R3 after flush");
      pr(mk(0, 3, 1), 1'b0, "R3 after flush");

      // R5: pseudo-random sweep against the model
      lfsr = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
         logic [15:0] r;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         r = lfsr;
         op(r[0] | r[1], mk(int'(r[3:2]), int'(r[6:4]), int'(r[8:7])), r[9],
            r[10] | r[11], mk(int'(r[15:14]), int'(r[13:12] ^ r[6:5]), int'(r[8:7] ^ {1'b0, r[15]})),
            (r[15:10] == 6'h2A), "R5 sweep");
      end

      op(1'b0, '0, 1'b0, 1'b0, '0, 1'b0, "R5 idle");
      check("R5 idle", probe_hit, 1'b0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule